// File: doc/BRIEF.md
# SPI Master Register Front End

This block sits between a simple memory-style bus and the shift engine of an SPI master. Software configures the engine through a control word and picks interrupt sources through a mask word. It reads the flags through a status word and moves payload through a data word. The front end holds one outgoing word and one incoming word. It flags an incoming word that overwrites one nobody has read, and it drives one level-sensitive interrupt.

The bus has a write port (address, data, write strobe) and a read port (address, read strobe). Read data follows the read address combinationally. State changes only when the read strobe is high. The shift engine is reached through a valid/ready pair for outgoing words, a valid pulse for incoming words and a busy level. The control word is exported unchanged to the engine.

There are two small state machines. The transmit holder has the states `TXB_EMPTY` and `TXB_FULL`. It takes *load* (TXB_EMPTY to TXB_FULL, on a data-word write) and *handoff* (TXB_FULL to TXB_EMPTY, when the engine takes the word while enabled). The receive holder has the states `RXB_EMPTY` and `RXB_FULL`. It takes *capture* (RXB_EMPTY to RXB_FULL), *overrun* (RXB_FULL to RXB_FULL, with a new word arriving) and *drain* (RXB_FULL to RXB_EMPTY, on a strobed data-word read with no arrival in the same cycle).

Top module: `spi_rf`

## Requirements
- R1: After reset the control word reads 0, the mask word reads 0, the status word reads 0x2 (only the transmit-empty flag set), tx_valid_o is low and irq_o is low.
- R2: The addresses are: control 0, mask 1, status 2, data 3. The control word keeps these bits: enable 0, master 1, transmit enable 2, receive enable 3, clock polarity 4, clock phase 5, LSB-first 6, wide size 10, divider 22:20. All other control bits read as 0.
- R3: The mask word keeps bits 1:0 only. A write to the status word has no effect.
- R4: A data-word write while transmit-empty (status bit 1) is set loads the word. From the next cycle, transmit-empty reads 0 and tx_data_o holds the word, cut to its low 8 bits when control bit 10 is 0 and to its low 16 bits when it is 1.
- R5: A data-word write while transmit-empty is clear is ignored, and tx_data_o keeps the earlier word.
- R6: tx_valid_o is high while a word is held and control bit 0 is set, and low while that bit is clear. tx_data_o is stable until tx_ready_i is seen with tx_valid_o. Transmit-empty is set again in the cycle after that handshake.
- R7: An rx_valid_i pulse is taken only while control bits 0 and 3 are both set. A taken word sets receive-full (status bit 1 is transmit-empty, bit 0 is receive-full) and reads back from the data word, cut to the current size.
- R8: Read data follows the read address combinationally. A read without the strobe changes nothing. A strobed data-word read clears receive-full.
- R9: A word taken while receive-full is set, and no strobed data-word read happens in that cycle, sets lost (status bit 4). The newest word is kept. A strobed status read clears lost. A word that arrives in the same cycle as a strobed data-word read does not set lost.
- R10: Status bit 3 follows eng_busy_i.
- R11: irq_o is high exactly when a status bit among receive-full and transmit-empty is set together with the mask bit at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_waddr | input | 2 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_raddr | input | 2 | Read address |
| bus_re | input | 1 | Read strobe (enables read side effects) |
| bus_rdata | output | 32 | Combinational read data |
| cfg_o | output | 32 | Control word to the shift engine |
| tx_valid_o | output | 1 | Outgoing word available |
| tx_data_o | output | 16 | Outgoing word |
| tx_ready_i | input | 1 | Engine takes the outgoing word |
| rx_valid_i | input | 1 | Incoming word pulse |
| rx_data_i | input | 16 | Incoming word |
| eng_busy_i | input | 1 | Engine busy level |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong state in either holder reaches the ports at once. The status word and irq_o are combinational from the holder states, so a stale or missed transition shows in the first read after the edge that should have caused it. A wrong transmit state also shows on tx_valid_o in that same cycle. A wrong lost flag or a misplaced drain shows on the first status read that follows. A corrupted data register shows on tx_data_o, or on the next unstrobed data-word read.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_IMASK  = 2'd1,
        ADDR_STATUS = 2'd2,
        ADDR_DATA   = 2'd3
    } rf_addr_e;

    // control word bit positions
    localparam int C_EN     = 0;
    localparam int C_MASTER = 1;
    localparam int C_TXEN   = 2;
    localparam int C_RXEN   = 3;
    localparam int C_CPOL   = 4;
    localparam int C_CPHA   = 5;
    localparam int C_LSBF   = 6;
    localparam int C_WIDE   = 10;
    localparam int C_DIV_LO = 20;
    localparam int C_DIV_W  = 3;

    // status word bit positions
    localparam int S_RXFULL = 0;
    localparam int S_TXEMP  = 1;
    localparam int S_BUSY   = 3;
    localparam int S_LOST   = 4;

    localparam int IRQ_SRC_W = 2;

    typedef enum logic {
        TXB_EMPTY = 1'b0,
        TXB_FULL  = 1'b1
    } txb_state_e;

    typedef enum logic {
        RXB_EMPTY = 1'b0,
        RXB_FULL  = 1'b1
    } rxb_state_e;

endpackage

// File: rtl/spi_rf_txbuf.sv
module spi_rf_txbuf
    import spi_rf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_data_i,
    input  logic          enable_i,
    input  logic          tx_ready_i,
    output logic          tx_valid_o,
    output logic [DW-1:0] tx_data_o,
    output logic          empty_o
);

    txb_state_e state_q, state_d;
    logic [DW-1:0] word_q;
    logic take;

    assign take = (state_q == TXB_EMPTY) && load_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXB_EMPTY: if (load_i)                state_d = TXB_FULL;
            TXB_FULL:  if (enable_i && tx_ready_i) state_d = TXB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXB_EMPTY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) word_q <= load_data_i;
        end
    end

    always_comb begin
        tx_valid_o = (state_q == TXB_FULL) && enable_i;
        tx_data_o  = word_q;
        empty_o    = (state_q == TXB_EMPTY);
    end

    // R6
    held_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> $stable(tx_data_o));

    // R5
    ignored_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !empty_o) |=> $stable(tx_data_o));

    // R6
    refill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i) |=> empty_o);

endmodule

// File: rtl/spi_rf_rxbuf.sv
module spi_rf_rxbuf
    import spi_rf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    input  logic          clr_lost_i,
    output logic          full_o,
    output logic          lost_o,
    output logic [DW-1:0] data_o
);

    rxb_state_e state_q, state_d;
    logic [DW-1:0] word_q;
    logic lost_q;
    logic overrun;

    assign overrun = (state_q == RXB_FULL) && push_i && !pop_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXB_EMPTY: if (push_i)            state_d = RXB_FULL;
            RXB_FULL:  if (pop_i && !push_i)  state_d = RXB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXB_EMPTY;
            word_q  <= '0;
            lost_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (push_i)          word_q <= push_data_i;
            if (overrun)         lost_q <= 1'b1;
            else if (clr_lost_i) lost_q <= 1'b0;
        end
    end

    always_comb begin
        full_o = (state_q == RXB_FULL);
        lost_o = lost_q;
        data_o = word_q;
    end

    // R9
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> lost_o);

    // R8
    drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> !full_o);

    // R7
    capture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (full_o && data_o == $past(push_data_i)));

endmodule

// File: rtl/spi_rf.sv
module spi_rf
    import spi_rf_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_raddr,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [BUS_W-1:0]  cfg_o,
    output logic              tx_valid_o,
    output logic [DW-1:0]     tx_data_o,
    input  logic              tx_ready_i,
    input  logic              rx_valid_i,
    input  logic [DW-1:0]     rx_data_i,
    input  logic              eng_busy_i,
    output logic              irq_o
);

    localparam logic [BUS_W-1:0] CTRL_KEEP =
        (BUS_W'(1) << C_EN)   | (BUS_W'(1) << C_MASTER) |
        (BUS_W'(1) << C_TXEN) | (BUS_W'(1) << C_RXEN)   |
        (BUS_W'(1) << C_CPOL) | (BUS_W'(1) << C_CPHA)   |
        (BUS_W'(1) << C_LSBF) | (BUS_W'(1) << C_WIDE)   |
        (((BUS_W'(1) << C_DIV_W) - BUS_W'(1)) << C_DIV_LO);

    logic [BUS_W-1:0]     ctrl_q;
    logic [IRQ_SRC_W-1:0] imask_q;
    logic [BUS_W-1:0]     status;
    logic                 wide, tx_empty, rx_full, rx_lost;
    logic                 data_wr, data_rd, stat_rd, rx_take;
    logic [DW-1:0]        rx_word;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic w);
        return w ? v : {{(DW-SW){1'b0}}, v[SW-1:0]};
    endfunction

    assign wide    = ctrl_q[C_WIDE];
    assign data_wr = bus_we && (bus_waddr == ADDR_DATA);
    assign data_rd = bus_re && (bus_raddr == ADDR_DATA);
    assign stat_rd = bus_re && (bus_raddr == ADDR_STATUS);
    assign rx_take = rx_valid_i && ctrl_q[C_EN] && ctrl_q[C_RXEN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            imask_q <= '0;
        end else if (bus_we) begin
            if (bus_waddr == ADDR_CTRL)  ctrl_q  <= bus_wdata & CTRL_KEEP;
            if (bus_waddr == ADDR_IMASK) imask_q <= bus_wdata[IRQ_SRC_W-1:0];
        end
    end

    spi_rf_txbuf #(.DW(DW)) u_txbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (data_wr),
        .load_data_i (fit(bus_wdata[DW-1:0], wide)),
        .enable_i    (ctrl_q[C_EN]),
        .tx_ready_i  (tx_ready_i),
        .tx_valid_o  (tx_valid_o),
        .tx_data_o   (tx_data_o),
        .empty_o     (tx_empty)
    );

    spi_rf_rxbuf #(.DW(DW)) u_rxbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_take),
        .push_data_i (fit(rx_data_i, wide)),
        .pop_i       (data_rd),
        .clr_lost_i  (stat_rd),
        .full_o      (rx_full),
        .lost_o      (rx_lost),
        .data_o      (rx_word)
    );

    always_comb begin
        status           = '0;
        status[S_RXFULL] = rx_full;
        status[S_TXEMP]  = tx_empty;
        status[S_BUSY]   = eng_busy_i;
        status[S_LOST]   = rx_lost;
    end

    always_comb begin
        unique case (bus_raddr)
            ADDR_CTRL:   bus_rdata = ctrl_q;
            ADDR_IMASK:  bus_rdata = {{(BUS_W-IRQ_SRC_W){1'b0}}, imask_q};
            ADDR_STATUS: bus_rdata = status;
            ADDR_DATA:   bus_rdata = {{(BUS_W-DW){1'b0}}, rx_word};
            default:     bus_rdata = '0;
        endcase
    end

    assign cfg_o = ctrl_q;
    assign irq_o = |(status[IRQ_SRC_W-1:0] & imask_q);

    // R11
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == '0) |-> !irq_o);

    // R6
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[C_EN] |-> !tx_valid_o);

    // R7
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full && !(ctrl_q[C_EN] && ctrl_q[C_RXEN])) |=> !rx_full);

endmodule

// File: tb/spi_rf_bench.sv
module spi_rf_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_waddr = '0, bus_raddr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_rdata, cfg_o;
    logic        tx_valid_o, tx_ready_i = 1'b0;
    logic [15:0] tx_data_o, rx_data_i = '0;
    logic        rx_valid_i = 1'b0, eng_busy_i = 1'b0, irq_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_rf u_spi_rf (.*);

    // {write, strobe, req[3:0], addr[1:0], data[31:0], expect[31:0]}
    localparam int NV = 16;
    localparam logic [71:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'd1, 2'd0, 32'h0, 32'h0},              // R1 control
        {1'b0, 1'b0, 4'd1, 2'd1, 32'h0, 32'h0},              // R1 mask
        {1'b0, 1'b0, 4'd1, 2'd2, 32'h0, 32'h2},              // R1 status
        {1'b0, 1'b0, 4'd1, 2'd3, 32'h0, 32'h0},              // R1 data
        {1'b1, 1'b0, 4'd2, 2'd0, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 1'b0, 4'd2, 2'd0, 32'h0, 32'h0070_047F},      // R2 kept bits
        {1'b1, 1'b0, 4'd3, 2'd1, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 1'b0, 4'd3, 2'd1, 32'h0, 32'h3},              // R3 mask width
        {1'b1, 1'b0, 4'd3, 2'd2, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 1'b1, 4'd3, 2'd2, 32'h0, 32'h2},              // R3 status write ignored
        {1'b1, 1'b0, 4'd3, 2'd1, 32'h0, 32'h0},
        {1'b1, 1'b0, 4'd2, 2'd0, 32'h0, 32'h0},
        {1'b0, 1'b0, 4'd2, 2'd0, 32'h0, 32'h0},              // R2 cleared
        {1'b1, 1'b0, 4'd2, 2'd0, 32'h8030_0421, 32'h0},
        {1'b0, 1'b0, 4'd2, 2'd0, 32'h0, 32'h0030_0421},      // R2 partial
        {1'b1, 1'b0, 4'd2, 2'd0, 32'h0, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_waddr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic stb, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_raddr = a; bus_re = stb;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic push_rx(input logic [15:0] d);
        @(negedge clk);
        rx_valid_i = 1'b1; rx_data_i = d;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic handoff;
        @(negedge clk);
        tx_ready_i = 1'b1;
        @(negedge clk);
        tx_ready_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_valid", {31'b0, tx_valid_o}, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][71]) bus_write(VEC[i][65:64], VEC[i][63:32]);
            else bus_read(VEC[i][65:64], VEC[i][70], VEC[i][31:0],
                          $sformatf("R%0d vec%0d", VEC[i][69:66], i));
        end

        // R4: narrow load
        bus_write(2'd0, 32'h0000_000F);
        bus_write(2'd3, 32'h1234_ABCD);
        check("R4 narrow data", {16'b0, tx_data_o}, 32'h0000_00CD);
        check("R6 valid held", {31'b0, tx_valid_o}, 32'h1);
        bus_read(2'd2, 1'b0, 32'h0, "R4 tx empty cleared");
        // R5: write while full ignored
        bus_write(2'd3, 32'h0000_0055);
        check("R5 data kept", {16'b0, tx_data_o}, 32'h0000_00CD);
        // R6: enable gates valid
        bus_write(2'd0, 32'h0000_000E);
        check("R6 valid off when disabled", {31'b0, tx_valid_o}, 32'h0);
        handoff();
        bus_read(2'd2, 1'b0, 32'h0, "R6 no handoff while disabled");
        bus_write(2'd0, 32'h0000_000F);
        check("R6 valid back", {31'b0, tx_valid_o}, 32'h1);
        handoff();
        bus_read(2'd2, 1'b0, 32'h2, "R6 empty after handoff");
        check("R6 valid drops", {31'b0, tx_valid_o}, 32'h0);
        // R4: wide load
        bus_write(2'd0, 32'h0000_040F);
        bus_write(2'd3, 32'h1234_ABCD);
        check("R4 wide data", {16'b0, tx_data_o}, 32'h0000_ABCD);
        handoff();

        // R7: receive gated by RX enable
        bus_write(2'd0, 32'h0000_0407);
        push_rx(16'h1111);
        bus_read(2'd2, 1'b0, 32'h2, "R7 rx disabled");
        bus_write(2'd0, 32'h0000_040F);
        push_rx(16'h5A5A);
        bus_read(2'd2, 1'b0, 32'h3, "R7 rx full");
        // R8: unstrobed reads leave state
        bus_read(2'd3, 1'b0, 32'h5A5A, "R8 peek data");
        bus_read(2'd3, 1'b0, 32'h5A5A, "R8 peek again");
        bus_read(2'd2, 1'b0, 32'h3, "R8 still full");
        bus_read(2'd3, 1'b1, 32'h5A5A, "R8 strobed read");
        bus_read(2'd2, 1'b0, 32'h2, "R8 drained");

        // R9: overrun
        push_rx(16'h0011);
        push_rx(16'h0022);
        bus_read(2'd2, 1'b0, 32'h13, "R9 lost set");
        bus_read(2'd3, 1'b0, 32'h22, "R9 newest kept");
        bus_read(2'd2, 1'b1, 32'h13, "R9 strobed status");
        bus_read(2'd2, 1'b0, 32'h3, "R9 lost cleared");
        @(negedge clk);
        rx_valid_i = 1'b1; rx_data_i = 16'h0044; bus_raddr = 2'd3; bus_re = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0; bus_re = 1'b0;
        bus_read(2'd2, 1'b0, 32'h3, "R9 same-cycle drain not lost");
        bus_read(2'd3, 1'b1, 32'h44, "R9 refilled word");
        // R7: narrow receive
        bus_write(2'd0, 32'h0000_000F);
        push_rx(16'hABCD);
        bus_read(2'd3, 1'b1, 32'hCD, "R7 narrow rx");

        // R10: busy mirror
        @(negedge clk) eng_busy_i = 1'b1;
        bus_read(2'd2, 1'b0, 32'hA, "R10 busy");
        @(negedge clk) eng_busy_i = 1'b0;
        bus_read(2'd2, 1'b0, 32'h2, "R10 idle");

        // R11: interrupt
        check("R11 no mask", {31'b0, irq_o}, 32'h0);
        bus_write(2'd1, 32'h2);
        check("R11 tx empty source", {31'b0, irq_o}, 32'h1);
        bus_write(2'd1, 32'h1);
        check("R11 rx source idle", {31'b0, irq_o}, 32'h0);
        push_rx(16'h0077);
        check("R11 rx source", {31'b0, irq_o}, 32'h1);
        bus_read(2'd3, 1'b1, 32'h77, "R11 drain");
        check("R11 irq drops", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule